// File: doc/BRIEF.md
# Up/Down Reload Timer with Capture

This block is a 16-bit timer/counter with one 16-bit companion register that acts either as a capture register or as a reload value. It advances by one each cycle in which both the run control and the count-enable tick are high. An external pin, brought in through a two-flop synchroniser, can trigger a capture or a reload on its falling edge. In down-count mode the pin's level sets the count direction instead.

In the two up-counting reload modes, the counter reloads from the companion register when it passes all-ones. In down-counting mode it does not stop at zero. It watches for a match with the companion register, and on a match it jumps to all-ones. Two sticky flags report what happened: one for an overflow or underflow, and one for an external event. Each flag stays set until its clear input is pulsed. A write port loads the counter or the companion register directly.

Top module: `updown_reload_timer`

## Requirements
- R1: After reset the counter, the companion register, the overflow flag and the external flag all read zero.
- R2: The counter changes only in a cycle where runEn and tickEn are both 1, or on a write or a reload event. Otherwise it holds its value.
- R3: Reload mode is selected by captureSel=0 and downEn=0. On a counting cycle the counter increments. If the counter is at all-ones on a counting cycle, it loads the companion register and ovfFlag is set.
- R4: With captureSel=0 and downEn=1, a synchronised pin level of 1 gives up-counting that behaves as in R3.
- R5: With captureSel=0 and downEn=1, a synchronised pin level of 0 gives down-counting. On a counting cycle where the counter equals the companion register, the counter loads all-ones and ovfFlag is set. On any other counting cycle the counter decrements.
- R6: extPin is sampled on every rising edge. A new level, or a falling edge, first takes effect on the third rising edge that sees it, counting the sampling edge as the first.
- R7: Capture mode is selected by captureSel=1. A synchronised falling edge with extEn=1 copies the counter into the companion register and sets extFlag. The counter keeps counting that cycle. A count step from all-ones wraps to zero and sets ovfFlag, with no reload.
- R8: In reload mode with downEn=0, a synchronised falling edge with extEn=1 loads the counter from the companion register and sets extFlag. This load replaces the count step of that cycle.
- R9: With extEn=0, pin edges cause no capture or reload and leave extFlag unchanged. With captureSel=0 and downEn=1, pin edges cause no reload and do not set extFlag.
- R10: ovfFlag and extFlag stay at 1 until ovfClr or extClr is pulsed. If a set and a clear arrive in the same cycle, the flag ends up set.
- R11: When wrEn=1, wrSel=0 writes wrData into the counter and wrSel=1 writes wrData into the companion register. A write takes precedence over any hardware update of the same register in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Run control; counting stops while this is 0 |
| tickEn | input | 1 | Count-enable tick |
| extPin | input | 1 | Asynchronous external event / direction pin |
| extEn | input | 1 | Lets pin falling edges trigger capture or reload |
| downEn | input | 1 | In reload mode, lets the pin level choose the count direction |
| captureSel | input | 1 | 1 selects capture mode, 0 selects reload mode |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 1 | Write target: 0 selects the counter, 1 selects the companion register |
| wrData | input | 16 | Write data |
| ovfClr | input | 1 | Clears ovfFlag |
| extClr | input | 1 | Clears extFlag |
| timerVal | output | 16 | Current counter value |
| capVal | output | 16 | Companion (capture/reload) register |
| ovfFlag | output | 1 | Sticky overflow/underflow flag |
| extFlag | output | 1 | Sticky external-event flag |

## Verification
The hardest case to reach is the down-count match. The counter has to descend onto the companion value while the synchronised pin is low. It also has to get there without a stray up-count or write, because either one would move it back up by nearly 64K steps. Directed stimulus first writes the companion register. It then drives the pin low and waits out the synchroniser, and only then writes the counter a few steps above the match, so the match falls within a handful of ticks. A second corner is a pin falling edge that lands in the same cycle as an overflow. Randomised stimulus keeps the counter and the companion value near all-ones and toggles the pin often, so that such collisions occur repeatedly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Step command from control to datapath
  typedef struct packed {
    logic incr;     // add one
    logic decr;     // subtract one
    logic loadCap;  // counter <= companion register
    logic loadMax;  // counter <= all ones
    logic capture;  // companion register <= counter
  } stepCmd_t;

  localparam logic WR_TIMER = 1'b0;
  localparam logic WR_CAP   = 1'b1;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic pinLvl,
  output logic pinFall
);
  logic [STAGES-1:0] chain;
  logic              lastLvl;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= pinIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[gi] <= 1'b0;
          else       chain[gi] <= chain[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) lastLvl <= 1'b0;
    else       lastLvl <= chain[STAGES-1];

  assign pinLvl  = chain[STAGES-1];
  assign pinFall = lastLvl & ~chain[STAGES-1];

  // R6: a detected fall means the previous synchronised sample was high
  p_fall_prev_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    pinFall |-> $past(pinLvl));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     runEn,
  input  logic     tickEn,
  input  logic     extEn,
  input  logic     downEn,
  input  logic     captureSel,
  input  logic     pinLvl,
  input  logic     pinFall,
  input  logic     atMax,
  input  logic     atCap,
  input  logic     ovfClr,
  input  logic     extClr,
  output stepCmd_t cmd,
  output logic     ovfFlag,
  output logic     extFlag
);
  logic step, dirMode, extHit, ovfSet, extSet;

  assign step    = runEn & tickEn;
  assign dirMode = ~captureSel & downEn;
  assign extHit  = pinFall & extEn & ~dirMode;

  always_comb begin
    cmd    = '0;
    ovfSet = 1'b0;
    extSet = 1'b0;
    if (captureSel) begin
      cmd.capture = extHit;
      extSet      = extHit;
      cmd.incr    = step;
      ovfSet      = step & atMax;
    end else if (dirMode) begin
      if (step) begin
        if (pinLvl) begin
          cmd.loadCap = atMax;
          cmd.incr    = ~atMax;
          ovfSet      = atMax;
        end else begin
          cmd.loadMax = atCap;
          cmd.decr    = ~atCap;
          ovfSet      = atCap;
        end
      end
    end else begin
      extSet = extHit;
      ovfSet = step & atMax;
      if (extHit)    cmd.loadCap = 1'b1;
      else if (step) begin
        cmd.loadCap = atMax;
        cmd.incr    = ~atMax;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      extFlag <= 1'b0;
    end else begin
      if (ovfSet)      ovfFlag <= 1'b1;
      else if (ovfClr) ovfFlag <= 1'b0;
      if (extSet)      extFlag <= 1'b1;
      else if (extClr) extFlag <= 1'b0;
    end
  end

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);
  p_ext_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (extFlag && !extClr) |=> extFlag);
  p_one_timer_op_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones({cmd.incr, cmd.decr, cmd.loadCap, cmd.loadMax}) <= 1);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepCmd_t         cmd,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] timerVal,
  output logic [WIDTH-1:0] capVal,
  output logic             atMax,
  output logic             atCap
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] cnt, rel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (wrEn && wrSel == WR_TIMER) begin
      cnt <= wrData;
    end else if (cmd.loadCap) begin
      cnt <= rel;
    end else if (cmd.loadMax) begin
      cnt <= ALL_ONES;
    end else if (cmd.incr) begin
      cnt <= cnt + ONE;
    end else if (cmd.decr) begin
      cnt <= cnt - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          rel <= '0;
    else if (wrEn && wrSel == WR_CAP)   rel <= wrData;
    else if (cmd.capture)               rel <= cnt;
  end

  assign timerVal = cnt;
  assign capVal   = rel;
  assign atMax    = (cnt == ALL_ONES);
  assign atCap    = (cnt == rel);

  p_incr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.incr && !wrEn) |=> cnt == $past(cnt) + ONE);
  p_decr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.decr && !wrEn) |=> cnt == $past(cnt) - ONE);
endmodule

// File: rtl/updown_reload_timer.sv
module updown_reload_timer #(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             tickEn,
  input  logic             extPin,
  input  logic             extEn,
  input  logic             downEn,
  input  logic             captureSel,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [WIDTH-1:0] wrData,
  input  logic             ovfClr,
  input  logic             extClr,
  output logic [WIDTH-1:0] timerVal,
  output logic [WIDTH-1:0] capVal,
  output logic             ovfFlag,
  output logic             extFlag
);
  import tmr_pkg::*;

  stepCmd_t cmd;
  logic     pinLvl, pinFall, atMax, atCap;

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .pinIn(extPin), .pinLvl(pinLvl), .pinFall(pinFall)
  );

  tmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .tickEn(tickEn), .extEn(extEn),
    .downEn(downEn), .captureSel(captureSel), .pinLvl(pinLvl), .pinFall(pinFall),
    .atMax(atMax), .atCap(atCap), .ovfClr(ovfClr), .extClr(extClr),
    .cmd(cmd), .ovfFlag(ovfFlag), .extFlag(extFlag)
  );

  tmr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .timerVal(timerVal), .capVal(capVal), .atMax(atMax), .atCap(atCap)
  );

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!(runEn && tickEn) && !wrEn && !(pinFall && extEn)) |=> $stable(timerVal));
  p_down_match_r5: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && tickEn && !captureSel && downEn && !pinLvl && timerVal == capVal && !wrEn)
      |=> (timerVal == {WIDTH{1'b1}}) && ovfFlag);
  p_ignore_ext_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!extEn && !wrEn) |=> $stable(capVal));
  p_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    (captureSel && pinFall && extEn && !wrEn) |=> (capVal == $past(timerVal)) && extFlag);
endmodule

// File: tb/updown_reload_timer_test.sv
`timescale 1ns/1ps
module updown_reload_timer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 0, tickEn = 0, extPin = 0, extEn = 0, downEn = 0, captureSel = 0;
  logic wrEn = 0, wrSel = 0, ovfClr = 0, extClr = 0;
  logic [15:0] wrData = '0;
  logic [15:0] timerVal, capVal;
  logic ovfFlag, extFlag;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  updown_reload_timer uut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .tickEn(tickEn), .extPin(extPin),
    .extEn(extEn), .downEn(downEn), .captureSel(captureSel), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .ovfClr(ovfClr), .extClr(extClr),
    .timerVal(timerVal), .capVal(capVal), .ovfFlag(ovfFlag), .extFlag(extFlag)
  );

  // Reference model built from the requirements
  logic [15:0] mT, mC;
  logic mO, mE, s1, s2, s3;

  function automatic logic [15:0] nextTimer(logic [15:0] t, logic [15:0] c,
                                            logic lvl, logic fall);
    logic dc, ext, st;
    dc  = !captureSel && downEn;
    ext = fall && extEn && !dc;
    st  = runEn && tickEn;
    if (wrEn && !wrSel) return wrData;                        // R11
    if (captureSel) return st ? t + 16'd1 : t;                // R7
    if (dc) begin
      if (!st) return t;
      if (lvl) return (t == 16'hFFFF) ? c : t + 16'd1;        // R4
      return (t == c) ? 16'hFFFF : t - 16'd1;                 // R5
    end
    if (ext) return c;                                        // R8
    if (st) return (t == 16'hFFFF) ? c : t + 16'd1;           // R3
    return t;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mT = '0; mC = '0; mO = 0; mE = 0; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      logic fall, dc, ext, st, so, se;
      logic [15:0] nT, nC;
      fall = s3 && !s2;
      dc   = !captureSel && downEn;
      ext  = fall && extEn && !dc;
      st   = runEn && tickEn;
      nT   = nextTimer(mT, mC, s2, fall);
      nC   = mC;
      se   = ext;
      if (captureSel && ext) nC = mT;
      if (wrEn && wrSel) nC = wrData;
      if (captureSel)  so = st && mT == 16'hFFFF;
      else if (dc)     so = st && (s2 ? mT == 16'hFFFF : mT == mC);
      else             so = st && mT == 16'hFFFF;
      mO = so ? 1'b1 : (ovfClr ? 1'b0 : mO);
      mE = se ? 1'b1 : (extClr ? 1'b0 : mE);
      mT = nT; mC = nC;
      s3 = s2; s2 = s1; s1 = extPin;
    end
  end

  task automatic check(string tag);
    vectors++;
    if (timerVal !== mT || capVal !== mC || ovfFlag !== mO || extFlag !== mE) begin
      miscompares++;
      $display("FAIL %s: got t=%h c=%h o=%b e=%b exp t=%h c=%h o=%b e=%b",
               tag, timerVal, capVal, ovfFlag, extFlag, mT, mC, mO, mE);
    end
  endtask

  task automatic cyc(string tag, int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      wrEn = 0; ovfClr = 0; extClr = 0;
      check(tag);
    end
  endtask

  task automatic wr(logic sel, logic [15:0] d, string tag);
    wrEn = 1; wrSel = sel; wrData = d;
    cyc(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hang exp finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R1");
    rstN = 1;
    cyc("R1");
    // R11: writes with the counter stopped
    wr(1'b0, 16'hFFFD, "R11");
    wr(1'b1, 16'h1234, "R11");
    // R2: ticks without run, run without ticks
    tickEn = 1; cyc("R2", 3);
    tickEn = 0; runEn = 1; cyc("R2", 3);
    // R3: count through all-ones into reload
    tickEn = 1; cyc("R3", 5);
    // R10: clear, then set and clear together
    ovfClr = 1; cyc("R10");
    wr(1'b0, 16'hFFFF, "R11");
    ovfClr = 1; cyc("R10");
    cyc("R10", 2);
    // R11: write beats count in the same cycle
    wr(1'b0, 16'h0010, "R11");
    // R4: direction mode, pin high, up through overflow
    downEn = 1; extPin = 1; cyc("R6", 3);
    wr(1'b0, 16'hFFFE, "R4");
    cyc("R4", 4);
    // R5: pin low, descend onto the companion value
    extPin = 0; tickEn = 0; cyc("R6", 3);
    ovfClr = 1; cyc("R10");
    wr(1'b1, 16'h0100, "R11");
    wr(1'b0, 16'h0103, "R11");
    tickEn = 1; cyc("R5", 6);
    // R9: edges ignored in direction mode even with extEn
    extEn = 1; extPin = 1; cyc("R9", 4); extPin = 0; cyc("R9", 5);
    // R8: reload on falling edge
    downEn = 0; tickEn = 0;
    wr(1'b1, 16'hABCD, "R11");
    extPin = 1; cyc("R8", 4); extPin = 0; cyc("R6", 2); cyc("R8", 3);
    extClr = 1; cyc("R10");
    // R9: extEn low ignores edges
    extEn = 0; extPin = 1; cyc("R9", 4); extPin = 0; cyc("R9", 5);
    // R7: capture while counting, then wrap without reload
    captureSel = 1; extEn = 1; tickEn = 1;
    wr(1'b0, 16'h7000, "R11");
    extPin = 1; cyc("R7", 4); extPin = 0; cyc("R7", 5);
    wr(1'b0, 16'hFFFE, "R7");
    cyc("R7", 4);
    // Random mix with values kept near all-ones
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 0) begin
        runEn = r[4]; extEn = r[5]; downEn = r[6]; captureSel = r[7];
      end
      tickEn = r[8] | r[9];
      if (r[12:10] == 0) extPin = ~extPin;
      ovfClr = (r[15:13] == 0);
      extClr = (r[18:16] == 0);
      if (r[22:19] == 0) begin
        wrEn = 1; wrSel = r[23]; wrData = 16'hFFF0 | 16'(r[27:24]);
      end
      cyc("RND");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule